// File: doc/BRIEF.md
# Serial ADC Read Sequencer

This block is a host-side master for a serial successive-approximation ADC that uses a chip-select line and a serial clock. It makes both signals from the system clock. The serial clock half-period is a run-time setting. The block samples the ADC's 16-bit output frame and hands back the conversion result with a one-cycle valid strobe.

One start request runs one of three operations. A read frame returns data. A sleep frame puts the converter into power-down by releasing chip-select early. A wake frame is a full-length dummy frame whose data is discarded. The operation type is set only by the serial clock falling edge after which chip-select is released. The block remembers whether it has put the converter to sleep. A read request that arrives while the converter sleeps runs a wake frame first and then the read frame, as one busy period.

Between frames the block holds chip-select high for a programmable quiet time. The result width is a build parameter, 12 or 10 bits.

Top module: `adc_rd_seq`

## Requirements
- R1: After reset, cs_no and sclk_o are high and busy_o and valid_o are low. While cs_no is high, sclk_o is high.
- R2: Each serial clock phase lasts div_i+1 system clocks, using the div_i value captured at the start request. The first falling edge comes div_i+1 clocks after chip-select falls.
- R3: A read frame has 16 sclk falling edges, or 14 when short_i is 1. cs_no rises together with the sclk rise that follows the last falling edge.
- R4: At falling edge k (k = 1..16) the block samples stream bit k-1. Stream bits 0 and 1 are leading zeros. The result is stream bits 2 to RES_BITS+1, MSB first. valid_o pulses for one cycle in the cycle that cs_no rises, and result_o holds that value until the next read.
- R5: op_i = 1 runs a sleep frame. It releases chip-select after pd_edges_i falling edges, with the count clamped to 3..9. No valid_o pulse follows.
- R6: op_i = 2 runs a wake frame of 16 falling edges. No valid_o pulse follows.
- R7: A read (op_i = 0 or 3) issued after a sleep frame, with no wake frame between, runs a 16-edge wake frame and then the read frame. It gives exactly one valid_o pulse with correct data.
- R8: After each frame, cs_no stays high for quiet_i+1 system clocks before the chained frame starts, and busy_o stays high through that gap.
- R9: start_i is ignored while busy_o is high. The operation, divider and quiet settings of the running request do not change.
- R10: An accepted start drives cs_no low and busy_o high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 2 | 0/3 read, 1 sleep frame, 2 wake frame |
| short_i | input | 1 | Read frame of 14 edges instead of 16 |
| pd_edges_i | input | 4 | Sleep frame falling-edge count (clamped to 3..9) |
| div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| quiet_i | input | QUIET_W | Quiet gap minus one, in system clocks |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Chip-select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | RES_BITS | Last conversion result |
| valid_o | output | 1 | One-cycle strobe when result_o updates |
| busy_o | output | 1 | Request in progress |

## Verification
Busy and chip-select respond one cycle after an accepted start, and the bench checks them at the next falling clock edge. Every other result is due only once the whole request has finished. The bench waits for busy_o to fall, then compares the frame count, falling edges per frame, valid pulse count, captured result and the chained quiet gap against expectations computed from the settings it drove. A clock-by-clock monitor measures every serial clock phase against the captured half-period. A bench model of the converter returns a corrupted word while asleep, so a missing wake frame shows up as a wrong result.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_SLEEP = 2'd1, OP_WAKE = 2'd2, OP_READ_ALT = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_QUIET} st_e;
  localparam int FRAME_BITS = 16;
  localparam int SHORT_BITS = 14;
  localparam int PD_MIN     = 3;
  localparam int PD_MAX     = 9;
endpackage

// File: rtl/sclk_timer.sv
module sclk_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] hcnt;

  assign tick_o = run_i && (hcnt == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hcnt <= '0;
    else if (!run_i || tick_o) hcnt <= '0;
    else                        hcnt <= hcnt + 1'b1;
  end

  p_half_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> hcnt <= div_i);
endmodule

// File: rtl/frame_capture.sv
module frame_capture #(
  parameter int W     = 16,
  parameter int MSB   = 13,
  parameter int LSB   = 2,
  localparam int RW    = MSB - LSB + 1,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             smp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  output logic [RW-1:0]    data_o
);
  // stream bit idx lands at word position W-1-idx; keep only the result slice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else if (clr_i) data_o <= '0;
    else if (smp_i) begin
      for (int b = 0; b < RW; b++)
        if (idx_i == IDX_W'(W - 1 - LSB - b)) data_o[b] <= bit_i;
    end
  end

  p_clr_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_i |-> !clr_i);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int DIV_W    = 8,
  parameter int QUIET_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic                short_i,
  input  logic [3:0]          pd_edges_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [QUIET_W-1:0]  quiet_i,
  input  logic                sdata_i,
  output logic                cs_no,
  output logic                sclk_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                valid_o,
  output logic                busy_o
);
  localparam int EDGE_W  = $clog2(FRAME_BITS) + 1;
  localparam int IDX_W   = $clog2(FRAME_BITS);
  localparam int RES_MSB = FRAME_BITS - 3;
  localparam int RES_LSB = RES_MSB - RES_BITS + 1;

  st_e                 state;
  op_e                 kind_q;
  logic                chain_q, asleep_q, short_q, cs_q, sclk_q, valid_q;
  logic [EDGE_W-1:0]   edge_cnt, end_q;
  logic [DIV_W-1:0]    div_q;
  logic [QUIET_W-1:0]  quiet_q, qcnt;
  logic [RES_BITS-1:0] res_q, cap_data;
  logic                tick, smp, qdone, go_idle, go_chain;

  function automatic logic [EDGE_W-1:0] clamp_pd(input logic [3:0] v);
    if (v < 4'(PD_MIN)) return EDGE_W'(PD_MIN);
    if (v > 4'(PD_MAX)) return EDGE_W'(PD_MAX);
    return EDGE_W'(v);
  endfunction

  function automatic logic [EDGE_W-1:0] read_len(input logic s);
    return s ? EDGE_W'(SHORT_BITS) : EDGE_W'(FRAME_BITS);
  endfunction

  sclk_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state == ST_FRAME), .div_i(div_q), .tick_o(tick)
  );

  assign smp      = (state == ST_FRAME) && tick && sclk_q;
  assign qdone    = (state == ST_QUIET) && (qcnt == quiet_q);
  assign go_idle  = (state == ST_IDLE) && start_i;
  assign go_chain = qdone && chain_q;

  frame_capture #(.W(FRAME_BITS), .MSB(RES_MSB), .LSB(RES_LSB)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(go_idle || go_chain), .smp_i(smp),
    .idx_i(edge_cnt[IDX_W-1:0]), .bit_i(sdata_i), .data_o(cap_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      kind_q   <= OP_READ;
      chain_q  <= 1'b0;
      asleep_q <= 1'b0;
      short_q  <= 1'b0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      valid_q  <= 1'b0;
      edge_cnt <= '0;
      end_q    <= '0;
      div_q    <= '0;
      quiet_q  <= '0;
      qcnt     <= '0;
      res_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          state    <= ST_FRAME;
          cs_q     <= 1'b0;
          edge_cnt <= '0;
          div_q    <= div_i;
          quiet_q  <= quiet_i;
          short_q  <= short_i;
          chain_q  <= 1'b0;
          unique case (op_e'(op_i))
            OP_SLEEP: begin kind_q <= OP_SLEEP; end_q <= clamp_pd(pd_edges_i); end
            OP_WAKE:  begin kind_q <= OP_WAKE;  end_q <= EDGE_W'(FRAME_BITS); end
            default: begin
              if (asleep_q) begin
                kind_q  <= OP_WAKE;
                end_q   <= EDGE_W'(FRAME_BITS);
                chain_q <= 1'b1;
              end else begin
                kind_q <= OP_READ;
                end_q  <= read_len(short_i);
              end
            end
          endcase
        end
        ST_FRAME: if (tick) begin
          if (sclk_q) begin
            sclk_q   <= 1'b0;
            edge_cnt <= edge_cnt + 1'b1;
          end else begin
            sclk_q <= 1'b1;
            if (edge_cnt == end_q) begin
              cs_q  <= 1'b1;
              state <= ST_QUIET;
              qcnt  <= '0;
              if (kind_q == OP_READ) begin
                valid_q <= 1'b1;
                res_q   <= cap_data;
              end
              if (kind_q == OP_SLEEP) asleep_q <= 1'b1;
              if (kind_q == OP_WAKE)  asleep_q <= 1'b0;
            end
          end
        end
        ST_QUIET: begin
          if (qdone) begin
            if (chain_q) begin
              state    <= ST_FRAME;
              cs_q     <= 1'b0;
              edge_cnt <= '0;
              kind_q   <= OP_READ;
              end_q    <= read_len(short_q);
              chain_q  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            qcnt <= qcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_no    = cs_q;
  assign sclk_o   = sclk_q;
  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign busy_o   = (state != ST_IDLE);

  p_idle_sclk_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);
  p_phase_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FRAME && !tick) |=> $stable(sclk_q));
  p_edge_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_cnt <= EDGE_W'(FRAME_BITS));
  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_on_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));
  p_pd_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FRAME && kind_q == OP_SLEEP) |-> (end_q >= EDGE_W'(PD_MIN) && end_q <= EDGE_W'(PD_MAX)));
  p_awake_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FRAME && kind_q == OP_READ) |-> !asleep_q);
  p_quiet_cs_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_QUIET) |-> (cs_no && busy_o));
  p_settings_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(div_q) && $stable(quiet_q)));
endmodule

// File: tb/sim_adc_rd_seq.sv
module sim_adc_rd_seq;
  localparam int RES = 12;
  localparam logic [RES-1:0] MASK = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, short_r = 1'b0, sdata;
  logic [1:0] op = 2'd0;
  logic [3:0] pd = 4'd5;
  logic [7:0] dv = 8'd0, qt = 8'd0;
  logic cs_n, sclk, valid, busy;
  logic [RES-1:0] result;

  int ntest = 0, nfail = 0, cyc = 0;

  always #4 clk = ~clk;

  adc_rd_seq #(.RES_BITS(RES), .DIV_W(8), .QUIET_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .short_i(short_r),
    .pd_edges_i(pd), .div_i(dv), .quiet_i(qt), .sdata_i(sdata),
    .cs_no(cs_n), .sclk_o(sclk), .result_o(result), .valid_o(valid), .busy_o(busy)
  );

  // converter model
  logic [RES-1:0] adc_val = '0;
  logic [15:0] adc_word = '0;
  int adc_idx = 0, adc_edges = 0;
  bit adc_asleep = 0;
  assign sdata = cs_n ? 1'b1 : adc_word[15 - adc_idx];

  function automatic logic [15:0] frame_of(input logic [RES-1:0] v);
    return 16'(v) << (14 - RES);
  endfunction

  always @(negedge cs_n) begin
    adc_idx = 0; adc_edges = 0;
    adc_word = adc_asleep ? 16'h5A5A : frame_of(adc_val);
  end
  always @(negedge sclk) if (!cs_n) begin
    adc_edges++;
    if (adc_idx < 15) adc_idx++;
  end
  always @(posedge cs_n) begin
    if (adc_edges >= 10) adc_asleep = 0;
    else if (adc_edges >= 2) adc_asleep = 1;
  end

  // monitor
  int exp_half = 1, run = 0, medges = 0, gap = 0, last_gap = 0;
  int frames = 0, e_last = 0, e_prev = 0, bad_phase = 0, vcnt = 0;
  logic [RES-1:0] last_res = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!cs_n) begin
        if (prev_cs) begin last_gap = gap; run = 1; medges = 0; end
        else if (sclk != prev_sclk) begin
          if (run != exp_half) bad_phase++;
          run = 1;
          if (!sclk) medges++;
        end else run++;
      end else begin
        if (!prev_cs) begin
          if (run != exp_half) bad_phase++;
          e_prev = e_last; e_last = medges; frames++; gap = 1;
        end else gap++;
      end
      if (valid) begin vcnt++; last_res = result; end
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    chk(0, "watchdog", cyc, 150000);
    finish_run();
  end

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  bit exp_asleep = 0;

  task automatic do_op(input logic [1:0] o, input logic [3:0] p, input bit s,
                       input logic [7:0] d, input logic [7:0] q, input logic [RES-1:0] v);
    int f0, v0, ef, ee, ev;
    int clampv;
    @(negedge clk);
    op = o; pd = p; short_r = s; dv = d; qt = q; adc_val = v;
    exp_half = int'(d) + 1;
    f0 = frames; v0 = vcnt; bad_phase = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !cs_n, "R10 busy/cs after start", {30'd0, busy, cs_n}, 2);
    wait_idle();
    @(negedge clk);
    chk(bad_phase == 0, "R2 sclk phase width", bad_phase, 0);
    clampv = (p < 3) ? 3 : (p > 9) ? 9 : int'(p);
    if (o == 2'd1) begin
      ef = 1; ee = clampv; ev = 0;
      chk(e_last == ee, "R5 sleep frame edges", e_last, ee);
      chk(vcnt - v0 == 0, "R5 no valid on sleep", vcnt - v0, 0);
      exp_asleep = 1;
    end else if (o == 2'd2) begin
      ef = 1; ee = 16;
      chk(e_last == ee, "R6 wake frame edges", e_last, ee);
      chk(vcnt - v0 == 0, "R6 no valid on wake", vcnt - v0, 0);
      exp_asleep = 0;
    end else begin
      ee = s ? 14 : 16;
      ef = exp_asleep ? 2 : 1;
      chk(e_last == ee, "R3 read frame edges", e_last, ee);
      chk(vcnt - v0 == 1, "R4 one valid pulse", vcnt - v0, 1);
      chk(last_res == v, "R4 result value", int'(last_res), int'(v));
      chk(result == v, "R4 result held", int'(result), int'(v));
      if (exp_asleep) begin
        chk(e_prev == 16, "R7 wake frame before read", e_prev, 16);
        chk(last_gap == int'(q) + 1, "R8 chained quiet gap", last_gap, int'(q) + 1);
      end
      exp_asleep = 0;
    end
    chk(frames - f0 == ef, "R7 frame count", frames - f0, ef);
  endtask

  initial begin
    int f0, v0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !busy && !valid, "R1 reset state",
        {28'd0, cs_n, sclk, busy, valid}, 12);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && sclk && !busy && !valid, "R1 idle after reset",
        {28'd0, cs_n, sclk, busy, valid}, 12);

    do_op(2'd0, 4'd5, 0, 8'd0, 8'd0, 12'hABC);
    do_op(2'd3, 4'd5, 1, 8'd2, 8'd3, 12'h001);
    do_op(2'd0, 4'd5, 0, 8'd1, 8'd1, 12'hFFF);
    do_op(2'd1, 4'd0, 0, 8'd1, 8'd2, 12'h000);
    do_op(2'd0, 4'd5, 0, 8'd1, 8'd4, 12'h800);
    do_op(2'd1, 4'd15, 0, 8'd0, 8'd0, 12'h000);
    do_op(2'd2, 4'd5, 0, 8'd3, 8'd1, 12'h000);
    do_op(2'd0, 4'd5, 1, 8'd0, 8'd2, 12'h555);
    do_op(2'd1, 4'd5, 0, 8'd2, 8'd0, 12'h000);
    do_op(2'd0, 4'd5, 1, 8'd0, 8'd0, 12'h3C3);

    // R9: start while busy is ignored, settings changes mid-run have no effect
    @(negedge clk);
    op = 2'd0; short_r = 0; dv = 8'd2; qt = 8'd1; adc_val = 12'h6D2;
    exp_half = 3; f0 = frames; v0 = vcnt; bad_phase = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    op = 2'd1; pd = 4'd4; dv = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    @(negedge clk);
    chk(frames - f0 == 1, "R9 ignored start frame count", frames - f0, 1);
    chk(vcnt - v0 == 1 && last_res == 12'h6D2, "R9 read intact", int'(last_res), 12'h6D2);
    chk(bad_phase == 0, "R9 divider held", bad_phase, 0);
    do_op(2'd0, 4'd5, 0, 8'd0, 8'd0, 12'h0F0);

    for (int i = 0; i < 24; i++) begin
      int r;
      r = $urandom % 6;
      if (r == 0)      do_op(2'd1, 4'($urandom % 16), 0, 8'($urandom % 4), 8'($urandom % 8), '0);
      else if (r == 1) do_op(2'd2, 4'd5, 0, 8'($urandom % 4), 8'($urandom % 8), '0);
      else             do_op(2'($urandom % 2) == 0 ? 2'd0 : 2'd3, 4'd5, r == 2,
                             8'($urandom % 4), 8'($urandom % 8), RES'($urandom) & MASK);
    end
    finish_run();
  end
endmodule